// File: doc/BRIEF.md
# Linear Additive PUF Response Predictor

This block predicts the response of a two-chain delay PUF from a per-stage table of signed delay offsets. Each table slot holds the change in the chain-to-chain delay difference that flipping one challenge bit from 0 to 1 causes, relative to a challenge of all zeros. Software or a calibration engine fills the table through a simple write port. A challenge is then presented with a valid strobe.

The block walks the challenge one stage per clock. For every bit that is set, it adds that stage's offset into a wide signed accumulator. When the walk finishes, it publishes the predicted difference and a one-cycle done pulse. It also publishes a response bit: 1 when the difference is positive and 0 when it is negative. An exact zero cannot be resolved, so it raises a separate undefined flag. The published results stay in place until the next prediction completes.

Top module: `puf_resp_predictor`

## Requirements
- R1: After reset, busy and done are 0, pred_diff is 0, resp_bit is 0, resp_undef is 1, and every table slot holds 0.
- R2: A cycle with tbl_wr_en high stores tbl_wr_data, a signed 16-bit value, into slot tbl_wr_idx. Slot i is the offset for challenge bit i, where bit 0 is the least significant bit of chal_bits. A later write to the same slot replaces the earlier value.
- R3: A cycle with chal_valid high while busy is 0 accepts chal_bits, and busy reads 1 in the following cycle.
- R4: done is a single-cycle pulse. It rises exactly NUM_STAGES clock edges after the accepting edge, and busy falls on that same edge.
- R5: When done is high, pred_diff equals the signed sum of the slots whose challenge bits are 1. The all-zero challenge gives 0.
- R6: A positive pred_diff gives resp_bit 1 with resp_undef 0. A negative pred_diff gives resp_bit 0 with resp_undef 0.
- R7: A pred_diff of exactly 0 gives resp_undef 1 with resp_bit 0.
- R8: A challenge presented while busy is 1 is ignored. The result that follows belongs to the challenge already accepted, and no extra done pulse follows it.
- R9: The accumulator is ACC_W bits wide, 20 bits by default. It cannot overflow: eight slots of -32768 sum to -262144, and eight slots of 32767 sum to 262136.
- R10: pred_diff, resp_bit and resp_undef change only on the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W (3) | Table slot to write |
| tbl_wr_data | input | ENTRY_W (16) | Signed offset in picoseconds |
| chal_valid | input | 1 | Challenge strobe |
| chal_bits | input | NUM_STAGES (8) | Challenge, bit i selects slot i |
| busy | output | 1 | Prediction in progress |
| done | output | 1 | One-cycle completion pulse |
| pred_diff | output | ACC_W (20) | Signed predicted delay difference |
| resp_bit | output | 1 | Predicted response |
| resp_undef | output | 1 | Difference is exactly zero |

## Verification
On every cycle, the assertions check the following:
- the latency from acceptance to done;
- the single-cycle width of done, and busy falling together with it;
- acceptance raising busy;
- the stability of the published results between done pulses;
- the agreement of resp_bit and resp_undef with the sign of pred_diff.

Only the bench scenarios can show the remaining behaviour. They confirm that the sums match hand-computed values for chosen tables and challenges, that slot i really belongs to bit i, and that a challenge arriving mid-walk leaves the result untouched. They also cover the extreme-value tables that would overflow a narrower accumulator.

// File: rtl/puf_pred_pkg.sv
package puf_pred_pkg;

  typedef struct packed {
    logic resp;
    logic undef;
  } verdict_t;

  // Sign decision on a sign-extended difference.
  function automatic verdict_t classify_diff(input logic signed [63:0] diff);
    verdict_t v;
    v.undef = (diff == 64'sd0);
    v.resp  = (diff > 64'sd0);
    return v;
  endfunction

  // Contribution of one stage: its offset when the bit is set, else zero.
  function automatic logic signed [63:0] stage_term(input logic sel,
                                                    input logic signed [63:0] offset);
    return sel ? offset : 64'sd0;
  endfunction

endpackage

// File: rtl/puf_offset_table.sv
module puf_offset_table #(
  parameter int NUM_STAGES = 8,
  parameter int ENTRY_W    = 16,
  parameter int IDX_W      = $clog2(NUM_STAGES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic signed [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic signed [ENTRY_W-1:0] rd_data
);

  logic signed [ENTRY_W-1:0] slot [NUM_STAGES];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)   slot[s] <= '0;
      else if (hit) slot[s] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/puf_stage_walker.sv
module puf_stage_walker #(
  parameter int NUM_STAGES = 8,
  parameter int IDX_W      = $clog2(NUM_STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] stage_idx,
  output logic             last_step
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STAGES - 1);

  assign last_step = busy && (stage_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      stage_idx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        stage_idx <= '0;
      end else if (busy) begin
        if (last_step) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          stage_idx <= '0;
        end else begin
          stage_idx <= stage_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/puf_diff_accum.sv
module puf_diff_accum
  import puf_pred_pkg::*;
#(
  parameter int NUM_STAGES = 8,
  parameter int ENTRY_W    = 16,
  parameter int ACC_W      = ENTRY_W + $clog2(NUM_STAGES + 1),
  parameter int IDX_W      = $clog2(NUM_STAGES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_STAGES-1:0]     chal_in,
  input  logic                      step_en,
  input  logic                      last_step,
  input  logic [IDX_W-1:0]          stage_idx,
  input  logic signed [ENTRY_W-1:0] offset,
  output logic signed [ACC_W-1:0]   pred_diff,
  output logic                      resp_bit,
  output logic                      resp_undef
);

  logic [NUM_STAGES-1:0]   chal_q;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_next;
  logic signed [63:0]      term;
  verdict_t                verdict;

  assign term     = stage_term(chal_q[stage_idx], 64'(offset));
  assign acc_next = acc + ACC_W'(term);
  assign verdict  = classify_diff(64'(acc_next));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chal_q     <= '0;
      acc        <= '0;
      pred_diff  <= '0;
      resp_bit   <= 1'b0;
      resp_undef <= 1'b1;
    end else if (start) begin
      chal_q <= chal_in;
      acc    <= '0;
    end else if (step_en) begin
      acc <= acc_next;
      if (last_step) begin
        pred_diff  <= acc_next;
        resp_bit   <= verdict.resp;
        resp_undef <= verdict.undef;
      end
    end
  end

endmodule

// File: rtl/puf_resp_predictor.sv
module puf_resp_predictor #(
  parameter int NUM_STAGES = 8,
  parameter int ENTRY_W    = 16,
  localparam int IDX_W     = $clog2(NUM_STAGES),
  localparam int ACC_W     = ENTRY_W + $clog2(NUM_STAGES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tbl_wr_en,
  input  logic [IDX_W-1:0]          tbl_wr_idx,
  input  logic signed [ENTRY_W-1:0] tbl_wr_data,
  input  logic                      chal_valid,
  input  logic [NUM_STAGES-1:0]     chal_bits,
  output logic                      busy,
  output logic                      done,
  output logic signed [ACC_W-1:0]   pred_diff,
  output logic                      resp_bit,
  output logic                      resp_undef
);

  logic                      accept_evt;
  logic                      last_step;
  logic [IDX_W-1:0]          stage_idx;
  logic signed [ENTRY_W-1:0] cur_offset;

  assign accept_evt = chal_valid && !busy;

  puf_offset_table #(.NUM_STAGES(NUM_STAGES), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx),
    .wr_data(tbl_wr_data), .rd_idx(stage_idx), .rd_data(cur_offset));

  puf_stage_walker #(.NUM_STAGES(NUM_STAGES), .IDX_W(IDX_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .busy(busy), .done(done),
    .stage_idx(stage_idx), .last_step(last_step));

  puf_diff_accum #(.NUM_STAGES(NUM_STAGES), .ENTRY_W(ENTRY_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .chal_in(chal_bits),
    .step_en(busy), .last_step(last_step), .stage_idx(stage_idx),
    .offset(cur_offset), .pred_diff(pred_diff), .resp_bit(resp_bit),
    .resp_undef(resp_undef));

endmodule

// File: rtl/puf_resp_predictor_chk.sv
module puf_resp_predictor_chk #(
  parameter int NUM_STAGES = 8,
  parameter int ACC_W      = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    accept_evt,
  input logic                    busy,
  input logic                    done,
  input logic signed [ACC_W-1:0] pred_diff,
  input logic                    resp_bit,
  input logic                    resp_undef
);

  logic [31:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          lat_cnt <= '0;
    else if (accept_evt) lat_cnt <= '0;
    else if (busy)       lat_cnt <= lat_cnt + 1;
  end

  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);

  assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 32'(NUM_STAGES)));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_positive_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_bit |-> (pred_diff > 0) && !resp_undef);

  assert_negative_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_diff < 0) |-> !resp_bit && !resp_undef);

  assert_zero_undef_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_diff == 0) |-> resp_undef && !resp_bit);

  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(pred_diff) || done);

endmodule

bind puf_resp_predictor puf_resp_predictor_chk #(.NUM_STAGES(NUM_STAGES), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_evt(accept_evt), .busy(busy), .done(done),
  .pred_diff(pred_diff), .resp_bit(resp_bit), .resp_undef(resp_undef));

// File: tb/puf_resp_predictor_bench.sv
`timescale 1ns/1ps
module puf_resp_predictor_bench;

  localparam int N  = 8;
  localparam int EW = 16;
  localparam int AW = 20;
  localparam int NV = 10;

  // Slot offsets used by the vector walk.
  localparam logic signed [15:0] TBL [N] = '{16'sd12, -16'sd7, 16'sd30, -16'sd45,
                                             16'sd5, -16'sd5, 16'sd100, -16'sd90};
  localparam logic [7:0] V_CHAL [NV] = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h30,
                                         8'hC0, 8'h08, 8'hFF, 8'hAA, 8'h55};
  localparam int V_DIFF [NV] = '{0, 12, -7, 35, 0, 10, -45, 0, -147, 147};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_wr_en = 1'b0;
  logic [2:0] tbl_wr_idx = '0;
  logic signed [EW-1:0] tbl_wr_data = '0;
  logic chal_valid = 1'b0;
  logic [N-1:0] chal_bits = '0;
  logic busy, done, resp_bit, resp_undef;
  logic signed [AW-1:0] pred_diff;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  puf_resp_predictor u_puf_resp_predictor (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_data(tbl_wr_data), .chal_valid(chal_valid), .chal_bits(chal_bits),
    .busy(busy), .done(done), .pred_diff(pred_diff), .resp_bit(resp_bit),
    .resp_undef(resp_undef));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_slot(input int idx, input int val);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = 3'(idx); tbl_wr_data = EW'(val);
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Presents a challenge, optionally pokes a second one mid-walk,
  // and waits for done, returning the observed latency.
  task automatic run_chal(input logic [N-1:0] c, input bit poke,
                          input logic [N-1:0] c2, output int lat);
    @(negedge clk);
    chal_valid = 1'b1; chal_bits = c;
    @(negedge clk);
    chal_valid = 1'b0;
    check(busy == 1'b1, "R3 busy after accept", int'(busy), 1);
    lat = 0;
    if (poke) begin
      chal_valid = 1'b1; chal_bits = c2;
    end
    while (!done && lat < 4 * N) begin
      @(negedge clk);
      lat++;
      if (lat == 3) chal_valid = 1'b0;
    end
    chal_valid = 1'b0;
  endtask

  function automatic int classify_ref(input int d);
    return (d > 0) ? 1 : 0;
  endfunction

  task automatic check_result(input int exp, input string tag);
    check(int'(pred_diff) == exp, {tag, " R5 sum"}, int'(pred_diff), exp);
    check(int'(resp_bit) == classify_ref(exp), {tag, (exp == 0) ? " R7 resp" : " R6 resp"},
          int'(resp_bit), classify_ref(exp));
    check(int'(resp_undef) == ((exp == 0) ? 1 : 0), {tag, (exp == 0) ? " R7 undef" : " R6 undef"},
          int'(resp_undef), (exp == 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 busy/done", int'({busy, done}), 0);
    check(pred_diff == 0, "R1 pred_diff", int'(pred_diff), 0);
    check(resp_bit == 0 && resp_undef == 1, "R1 resp/undef", int'({resp_bit, resp_undef}), 1);
    // R1 table cleared: all-ones challenge sums to zero
    run_chal(8'hFF, 0, 8'h00, lat);
    check(pred_diff == 0, "R1 table zero", int'(pred_diff), 0);

    // R2 load table, with a replaced slot 3
    write_slot(3, 999);
    for (int i = 0; i < N; i++) write_slot(i, int'(TBL[i]));

    // Vector walk: R4, R5, R6, R7
    for (int v = 0; v < NV; v++) begin
      run_chal(V_CHAL[v], 0, 8'h00, lat);
      check(lat == N, "R4 latency", lat, N);
      check(busy == 0, "R4 busy falls with done", int'(busy), 0);
      check_result(V_DIFF[v], $sformatf("vec%0d", v));
      @(negedge clk);
      check(done == 0, "R4 done single cycle", int'(done), 0);
    end
    // R2 slot/bit mapping and last write wins: bit 3 alone gives -45
    run_chal(8'h08, 0, 8'h00, lat);
    check(pred_diff == -45, "R2 slot replace", int'(pred_diff), -45);

    // R8 challenge while busy ignored; R10 results held afterwards
    run_chal(8'h04, 1, 8'h40, lat);
    check(lat == N, "R8 latency", lat, N);
    check_result(30, "R8");
    repeat (2 * N) begin
      @(negedge clk);
      check(done == 0, "R8 no extra done", int'(done), 0);
      check(pred_diff == 30, "R10 held", int'(pred_diff), 30);
    end

    // R9 extremes
    for (int i = 0; i < N; i++) write_slot(i, -32768);
    run_chal(8'hFF, 0, 8'h00, lat);
    check_result(-262144, "R9 min");
    for (int i = 0; i < N; i++) write_slot(i, 32767);
    run_chal(8'hFF, 0, 8'h00, lat);
    check_result(262136, "R9 max");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule